// File: doc/BRIEF.md
# Ordered Dial Combination Lock

This block is a small state machine that releases a lock only when three dial operations arrive in one fixed order. Each operation carries a turning direction and a dial number. It is offered on an input bus together with a strobe that is high for one cycle. The machine counts how many leading steps of the secret sequence have been seen. It raises its unlock output once the third step lands.

The default secret is: turn right to 13, then turn left to 22, then turn right to 3. Parameters can change all three steps. A wrong operation sends the count back to the start. If that wrong operation happens to be a valid first step, the count goes to one step done instead. Once open, the lock ignores further dial activity until a relock request or a synchronous reset closes it again. The current step count is visible as a two-bit stage output.

Top module: `combo_lock_fsm`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) forces stage to 0 and unlocked to 0 from that edge on, whatever the state was, including open.
- R2: With default parameters and op_dir 0 = right, 1 = left, the operations right-13, left-22, right-3 move stage 0→1→2→3. Each move is seen on the rising edge that samples the operation's op_valid. unlocked goes high on the same edge as stage becomes 3.
- R3: In a cycle with op_valid low and relock low, stage and unlocked keep their values, whatever op_dir and op_num carry.
- R4: A valid operation that is not the expected next step, and not right-13, returns stage 1 or 2 to 0. In stage 0 it leaves stage at 0.
- R5: A valid right-13 that is not the expected next step (in stage 1 or 2) sets stage to 1.
- R6: Direction is part of each step: left-13 from stage 0 and right-22 from stage 1 are treated as wrong operations.
- R7: In stage 3, valid operations of any value leave stage at 3 and unlocked at 1.
- R8: relock high at a rising edge sets stage to 0 and unlocked to 0 at that edge. relock takes priority over a valid operation in the same cycle.
- R9: unlocked is a registered output that is 1 exactly when stage is 3 (encoding: 0 idle, 1 first step done, 2 two steps done, 3 open).
- R10: The three correct operations presented in any other order never set stage to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Strobe marking a dial operation this cycle |
| op_dir | input | 1 | Turning direction, 0 right, 1 left |
| op_num | input | NUM_W | Dial number of the operation |
| relock | input | 1 | Close the lock and restart the sequence |
| stage | output | 2 | Steps of the sequence completed, 3 means open |
| unlocked | output | 1 | High while the lock is open |

## Verification
Every result of this block appears on the rising edge that samples the operation, relock or reset. There is no further pipeline stage. So stage and unlocked are due exactly one edge after the inputs are applied. The bench drives inputs on the falling edge and lets one rising edge pass. It then compares both outputs with its reference model on the next falling edge, in every cycle of the run. The model advances on the same stimulus at that rising edge. In this way gaps between operations, wrong orders, operations in the open state and relock collisions are all compared cycle by cycle.

// File: rtl/combo_lock_fsm.sv
module combo_lock_fsm #(
  parameter int NUM_W    = 6,
  parameter bit STEP1_DIR = 1'b0,
  parameter int STEP1_NUM = 13,
  parameter bit STEP2_DIR = 1'b1,
  parameter int STEP2_NUM = 22,
  parameter bit STEP3_DIR = 1'b0,
  parameter int STEP3_NUM = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic             op_dir,
  input  logic [NUM_W-1:0] op_num,
  input  logic             relock,
  output logic [1:0]       stage,
  output logic             unlocked
);

  localparam logic [1:0] ST_IDLE = 2'd0;
  localparam logic [1:0] ST_ONE  = 2'd1;
  localparam logic [1:0] ST_TWO  = 2'd2;
  localparam logic [1:0] ST_OPEN = 2'd3;

  logic [1:0] state_q, state_d;
  logic       hit1, hit2, hit3;

  assign hit1 = (op_dir == STEP1_DIR) && (op_num == NUM_W'(STEP1_NUM));
  assign hit2 = (op_dir == STEP2_DIR) && (op_num == NUM_W'(STEP2_NUM));
  assign hit3 = (op_dir == STEP3_DIR) && (op_num == NUM_W'(STEP3_NUM));

  always_comb begin
    state_d = state_q;
    if (relock) begin
      state_d = ST_IDLE;
    end else if (op_valid) begin
      case (state_q)
        ST_IDLE: state_d = hit1 ? ST_ONE : ST_IDLE;
        ST_ONE:  state_d = hit2 ? ST_TWO  : (hit1 ? ST_ONE : ST_IDLE);
        ST_TWO:  state_d = hit3 ? ST_OPEN : (hit1 ? ST_ONE : ST_IDLE);
        default: state_d = ST_OPEN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      unlocked <= 1'b0;
    end else begin
      state_q  <= state_d;
      unlocked <= (state_d == ST_OPEN);
    end
  end

  assign stage = state_q;

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !relock) |=> ($stable(stage) && $stable(unlocked))); // R3

  AST_OPEN_STAYS: assert property (@(posedge clk) disable iff (rst)
    (stage == ST_OPEN && !relock) |=> (stage == ST_OPEN && unlocked)); // R7

  AST_RELOCK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    relock |=> (stage == ST_IDLE && !unlocked)); // R8

  AST_OPEN_FROM_TWO: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> ($past(stage) == ST_TWO && $past(op_valid))); // R10

  AST_NO_SKIP: assert property (@(posedge clk) disable iff (rst)
    (stage != ST_OPEN) |=> (stage <= $past(stage) + 2'd1)); // R2

endmodule

// File: tb/sim_combo_lock_fsm.sv
`timescale 1ns/1ps
module sim_combo_lock_fsm;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic op_dir = 1'b0;
  logic [5:0] op_num = '0;
  logic relock = 1'b0;
  logic [1:0] stage;
  logic unlocked;

  int checks = 0;
  int errors = 0;
  int model = 0;
  int seq_dir [3] = '{0, 1, 0};
  int seq_num [3] = '{13, 22, 3};

  always #5 clk = ~clk;

  combo_lock_fsm u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_dir(op_dir),
    .op_num(op_num), .relock(relock), .stage(stage), .unlocked(unlocked)
  );

  function automatic bool_match(int k, bit d, int n);
    return (seq_dir[k] == int'(d)) && (seq_num[k] == n);
  endfunction

  task automatic cyc(input bit v, input bit d, input int n, input bit rl, input bit rs, input string tag);
    rst = rs; op_valid = v; op_dir = d; op_num = 6'(n); relock = rl;
    @(posedge clk);
    if (rs || rl) model = 0;
    else if (v) begin
      if (model == 3) model = 3;
      else if (bool_match(model, d, n)) model = model + 1;
      else if (bool_match(0, d, n)) model = 1;
      else model = 0;
    end
    @(negedge clk);
    checks++;
    if (int'(stage) !== model) begin
      errors++;
      $display("FAIL %s stage actual %0d expected %0d", tag, stage, model);
    end
    checks++;
    if (unlocked !== (model == 3)) begin
      errors++;
      $display("FAIL %s R9 unlocked actual %0b expected %0b", tag, unlocked, model == 3);
    end
  endtask

  task automatic op(input bit d, input int n, input string tag);
    cyc(1'b1, d, n, 1'b0, 1'b0, tag);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 1'b1, 22, 1'b0, 1'b0, tag);
  endtask

  task automatic do_relock(input string tag);
    cyc(1'b0, 1'b0, 0, 1'b1, 1'b0, tag);
  endtask

  initial begin
    @(negedge clk);
    cyc(1'b0, 1'b0, 0, 1'b0, 1'b1, "R1");
    cyc(1'b0, 1'b0, 0, 1'b0, 1'b1, "R1");
    idle("R3"); idle("R3");
    // R2 full sequence with gaps
    op(0, 13, "R2"); idle("R3"); op(1, 22, "R2"); idle("R3"); idle("R3"); op(0, 3, "R2");
    // R7 ignored while open
    op(0, 13, "R7"); op(1, 5, "R7"); op(0, 3, "R7"); idle("R7");
    do_relock("R8");
    // back to back correct sequence
    op(0, 13, "R2"); op(1, 22, "R2"); op(0, 3, "R2");
    cyc(1'b0, 1'b0, 0, 1'b0, 1'b1, "R1");
    // R4 wrong ops
    op(1, 40, "R4"); op(0, 13, "R4"); op(0, 14, "R4");
    op(0, 13, "R4"); op(1, 22, "R4"); op(1, 3, "R4");
    // R5 repeated first step
    op(0, 13, "R5"); op(0, 13, "R5"); op(1, 22, "R5"); op(0, 13, "R5"); op(1, 22, "R5"); op(0, 3, "R5");
    do_relock("R8");
    // R6 direction matters
    op(1, 13, "R6"); op(0, 13, "R6"); op(0, 22, "R6"); op(0, 3, "R6");
    // R10 other orders
    op(1, 22, "R10"); op(0, 13, "R10"); op(0, 3, "R10");
    op(0, 3, "R10"); op(1, 22, "R10"); op(0, 13, "R10");
    op(0, 13, "R10"); op(0, 3, "R10"); op(1, 22, "R10");
    op(0, 3, "R10"); op(0, 13, "R10"); op(1, 22, "R10");
    // R8 relock beats a valid op
    cyc(1'b1, 1'b0, 13, 1'b1, 1'b0, "R8");
    op(0, 13, "R8"); op(1, 22, "R8");
    cyc(1'b1, 1'b0, 3, 1'b1, 1'b0, "R8");
    // R1 reset while open, reset beats op
    op(0, 13, "R1"); op(1, 22, "R1"); op(0, 3, "R1");
    cyc(1'b1, 1'b0, 13, 1'b0, 1'b1, "R1");
    idle("R3");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule